// File: doc/BRIEF.md
# Wiper Position Register

This block keeps the 6-bit tap position of a digitally controlled resistor divider and turns it into a one-hot enable for the 64 tap switches. The value can change in four ways: a recall of stored slot 0 when power comes up, a direct write of a full value from the serial host logic, a quick transfer of a value taken from one of the stored data slots, and single-tap stepping while an increment/decrement session is open.

A small state machine runs the register. After reset it sits in `S_WAIT`, where the position is held at 0 and every request except recall is ignored. The transition `WAIT_TO_READY` is taken on a recall when the session enable is low, and `WAIT_TO_SESSION` when it is high. From `S_READY` the transition `READY_TO_SESSION` is taken once `step_en` is sampled high. From `S_SESSION` the transition `SESSION_TO_READY` is taken once `step_en` is sampled low. Otherwise a state holds (`READY_HOLD`, `SESSION_HOLD`). Step pulses count only in `S_SESSION`. The first pulse that arrives in the same cycle that `step_en` first rises is therefore dropped. When several requests arrive in the same cycle, recall wins over direct load, direct load over transfer, and transfer over a step.

Top module: `wiper_pos_reg`

## Requirements
- R1: `tap_sel` always has exactly one bit set, and that bit is at the index equal to `wiper_pos`.
- R2: Position 0 drives `tap_sel[0]`, the low-end tap. Position 63 drives `tap_sel[63]`, the high-end tap.
- R3: After reset `wiper_pos` is 0. It stays at 0, ignoring `load_req`, `xfer_req` and step pulses, until the first `recall_req`.
- R4: A `recall_req` sampled at a clock edge, in any state, makes `wiper_pos` equal `recall_data` after that edge.
- R5: Once recalled, a `load_req` replaces all 6 bits with `load_data` in one cycle.
- R6: Once recalled, an `xfer_req` writes `xfer_data` into the register in one cycle, with no wait states.
- R7: In a session, a `step_pulse` with `step_up`=1 raises the position by one. A `step_pulse` with `step_up`=0 lowers it by one.
- R8: Stepping up from 63 leaves 63, and stepping down from 0 leaves 0. The value never wraps.
- R9: Requests in the same cycle resolve with recall first, then load, then transfer, then step.
- R10: The session opens on the edge after `step_en` is sampled high and closes on the edge after it is sampled low. Step pulses outside an open session have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recall_req | input | 1 | Power-up recall strobe |
| recall_data | input | 6 | Contents of stored slot 0 |
| load_req | input | 1 | Direct host write strobe |
| load_data | input | 6 | Direct write value |
| xfer_req | input | 1 | Transfer-from-slot strobe |
| xfer_data | input | 6 | Value of the selected slot |
| step_en | input | 1 | Increment/decrement session enable |
| step_pulse | input | 1 | One qualified step pulse |
| step_up | input | 1 | Step direction: 1 toward the high end, 0 toward the low end |
| wiper_pos | output | 6 | Current tap position |
| tap_sel | output | 64 | One-hot tap switch enables |

## Verification
The assertions assume that every strobe is a single-cycle level that is already valid at the sampling edge, and that the data inputs are stable whenever their strobe is high. The bench drives every input on the falling clock edge, so each value is settled a half period before it is sampled. A saturation property is checked only when no request of higher priority competes in the same cycle. The bench deliberately drives such competing requests together so that the priority order is also covered.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
    localparam int POS_W_DEF = 6;

    typedef enum logic [1:0] {
        S_WAIT    = 2'd0,
        S_READY   = 2'd1,
        S_SESSION = 2'd2
    } wpr_state_t;
endpackage

// File: rtl/wpr_step.sv
module wpr_step #(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0] cur,
    input  logic             up,
    output logic [POS_W-1:0] nxt
);
    localparam logic [POS_W-1:0] TOP = '1;
    localparam logic [POS_W-1:0] BOT = '0;

    always_comb begin
        nxt = cur;
        if (up) begin
            if (cur != TOP) nxt = cur + 1'b1;
        end else begin
            if (cur != BOT) nxt = cur - 1'b1;
        end
    end
endmodule

// File: rtl/wpr_decode.sv
module wpr_decode #(
    parameter int POS_W = 6,
    localparam int TAPS = 1 << POS_W
) (
    input  logic [POS_W-1:0] pos,
    output logic [TAPS-1:0]  sel
);
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign sel[i] = (pos == POS_W'(i));
    end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
    import wpr_pkg::*;
#(
    parameter int POS_W = POS_W_DEF,
    localparam int TAPS = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             recall_req,
    input  logic [POS_W-1:0] recall_data,
    input  logic             load_req,
    input  logic [POS_W-1:0] load_data,
    input  logic             xfer_req,
    input  logic [POS_W-1:0] xfer_data,
    input  logic             step_en,
    input  logic             step_pulse,
    input  logic             step_up,
    output logic [POS_W-1:0] wiper_pos,
    output logic [TAPS-1:0]  tap_sel
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    wpr_state_t       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d, stepped;

    wpr_step #(.POS_W(POS_W)) u_step (
        .cur (pos_q),
        .up  (step_up),
        .nxt (stepped)
    );

    wpr_decode #(.POS_W(POS_W)) u_dec (
        .pos (pos_q),
        .sel (tap_sel)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_WAIT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT:    if (recall_req) state_d = step_en ? S_SESSION : S_READY;
            S_READY:   if (step_en)    state_d = S_SESSION;
            S_SESSION: if (!step_en)   state_d = S_READY;
            default:   state_d = S_WAIT;
        endcase
    end

    // position update, priority recall > load > transfer > step
    always_comb begin
        pos_d = pos_q;
        if (recall_req) begin
            pos_d = recall_data;
        end else begin
            unique case (state_q)
                S_WAIT:    pos_d = '0;
                S_READY: begin
                    if (load_req)      pos_d = load_data;
                    else if (xfer_req) pos_d = xfer_data;
                end
                S_SESSION: begin
                    if (load_req)        pos_d = load_data;
                    else if (xfer_req)   pos_d = xfer_data;
                    else if (step_pulse) pos_d = stepped;
                end
                default:   pos_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign wiper_pos = pos_q;

    // R1
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel) == 1 && tap_sel[wiper_pos]);

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_WAIT |-> wiper_pos == '0);

    // R4
    recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> wiper_pos == $past(recall_data));

    // R5
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_WAIT && load_req && !recall_req) |=> wiper_pos == $past(load_data));

    // R8
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SESSION && step_pulse && step_up && !recall_req && !load_req
         && !xfer_req && wiper_pos == POS_MAX) |=> wiper_pos == POS_MAX);

    // R8
    no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SESSION && step_pulse && !step_up && !recall_req && !load_req
         && !xfer_req && wiper_pos == '0) |=> wiper_pos == '0);

    // R10
    idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_READY && !recall_req && !load_req && !xfer_req) |=> $stable(wiper_pos));
endmodule

// File: tb/wiper_pos_reg_bench.sv
module wiper_pos_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        recall_req = 1'b0, load_req = 1'b0, xfer_req = 1'b0;
    logic [5:0]  recall_data = '0, load_data = '0, xfer_data = '0;
    logic        step_en = 1'b0, step_pulse = 1'b0, step_up = 1'b0;
    logic [5:0]  wiper_pos;
    logic [63:0] tap_sel;

    int    n_chk = 0, n_fail = 0;
    string phase = "R3";
    bit    done = 0;

    int ref_pos = 0;
    bit ref_armed = 0, ref_sess = 0;

    always #10 clk = ~clk;

    wiper_pos_reg u_wiper_pos_reg (
        .clk(clk), .rst_n(rst_n),
        .recall_req(recall_req), .recall_data(recall_data),
        .load_req(load_req), .load_data(load_data),
        .xfer_req(xfer_req), .xfer_data(xfer_data),
        .step_en(step_en), .step_pulse(step_pulse), .step_up(step_up),
        .wiper_pos(wiper_pos), .tap_sel(tap_sel)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        int nxt;
        if (!rst_n) begin
            ref_pos = 0; ref_armed = 0; ref_sess = 0;
        end else begin
            nxt = ref_pos;
            if (recall_req) nxt = int'(recall_data);
            else if (ref_armed) begin
                if (load_req)      nxt = int'(load_data);
                else if (xfer_req) nxt = int'(xfer_data);
                else if (ref_sess && step_pulse) begin
                    if (step_up) nxt = (ref_pos < 63) ? ref_pos + 1 : 63;
                    else         nxt = (ref_pos > 0)  ? ref_pos - 1 : 0;
                end
            end
            ref_sess  = (ref_armed || recall_req) && step_en;
            ref_armed = ref_armed || recall_req;
            ref_pos   = nxt;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare every cycle, well after the edge
    always @(posedge clk) begin
        logic [63:0] exp_sel;
        #5;
        if (!done) begin
            exp_sel = 64'd1 << ref_pos;
            chk(wiper_pos == 6'(ref_pos), phase, longint'(wiper_pos), longint'(ref_pos));
            // R1 one-hot at the position
            chk(tap_sel == exp_sel, "R1", longint'(tap_sel), longint'(exp_sel));
        end
    end

    task automatic drive(input bit rc, input int rd, input bit ld, input int lv,
                         input bit xf, input int xv, input bit en, input bit pl, input bit up);
        recall_req = rc; recall_data = 6'(rd);
        load_req = ld;   load_data = 6'(lv);
        xfer_req = xf;   xfer_data = 6'(xv);
        step_en = en;    step_pulse = pl; step_up = up;
        @(negedge clk);
    endtask

    task automatic idle(input bit en);
        drive(0, 0, 0, 0, 0, 0, en, 0, 0);
    endtask

    initial begin
        #(200000 * 20);
        $display("FAIL watchdog actual=timeout expected=finish");
        n_chk++; n_fail++;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3: nothing but recall moves the value after reset
        phase = "R3";
        drive(0, 0, 1, 5, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 9, 1, 0, 0);
        repeat (3) drive(0, 0, 0, 0, 0, 0, 1, 1, 1);
        idle(0);
        #1 chk(wiper_pos == 0, "R3", longint'(wiper_pos), 0);
        // R4
        phase = "R4";
        drive(1, 42, 0, 0, 0, 0, 0, 0, 0);
        idle(0);
        chk(wiper_pos == 42, "R4", longint'(wiper_pos), 42);
        // R5, R6
        phase = "R5"; drive(0, 0, 1, 17, 0, 0, 0, 0, 0); idle(0);
        chk(wiper_pos == 17, "R5", longint'(wiper_pos), 17);
        phase = "R6"; drive(0, 0, 0, 0, 1, 50, 0, 0, 0); idle(0);
        chk(wiper_pos == 50, "R6", longint'(wiper_pos), 50);
        // R2 ends of the array
        phase = "R2"; drive(0, 0, 1, 0, 0, 0, 0, 0, 0); idle(0);
        chk(tap_sel[0] == 1'b1, "R2", longint'(tap_sel), 1);
        drive(0, 0, 1, 63, 0, 0, 0, 0, 0); idle(0);
        chk(tap_sel[63] == 1'b1, "R2", longint'(tap_sel), longint'(64'd1 << 63));
        // R10: first pulse with the enable's rise is dropped
        phase = "R10";
        drive(0, 0, 1, 20, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 1, 1, 1);
        idle(1);
        chk(wiper_pos == 20, "R10", longint'(wiper_pos), 20);
        // R7
        phase = "R7";
        repeat (4) drive(0, 0, 0, 0, 0, 0, 1, 1, 1);
        repeat (2) drive(0, 0, 0, 0, 0, 0, 1, 1, 0);
        idle(1);
        chk(wiper_pos == 22, "R7", longint'(wiper_pos), 22);
        // R8 saturation at both ends
        phase = "R8";
        drive(0, 0, 1, 61, 0, 0, 1, 0, 0);
        repeat (5) drive(0, 0, 0, 0, 0, 0, 1, 1, 1);
        idle(1);
        chk(wiper_pos == 63, "R8", longint'(wiper_pos), 63);
        drive(0, 0, 1, 2, 0, 0, 1, 0, 0);
        repeat (5) drive(0, 0, 0, 0, 0, 0, 1, 1, 0);
        idle(1);
        chk(wiper_pos == 0, "R8", longint'(wiper_pos), 0);
        // R9 priority
        phase = "R9";
        drive(1, 11, 1, 22, 1, 33, 1, 1, 1); idle(1);
        chk(wiper_pos == 11, "R9", longint'(wiper_pos), 11);
        drive(0, 0, 1, 22, 1, 33, 1, 1, 1); idle(1);
        chk(wiper_pos == 22, "R9", longint'(wiper_pos), 22);
        drive(0, 0, 0, 0, 1, 33, 1, 1, 1); idle(1);
        chk(wiper_pos == 33, "R9", longint'(wiper_pos), 33);
        // R10: session closes, pulses ignored
        phase = "R10";
        idle(0);
        repeat (3) drive(0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk(wiper_pos == 33, "R10", longint'(wiper_pos), 33);
        // R4 recall inside a session
        phase = "R4";
        idle(1);
        drive(1, 7, 0, 0, 0, 0, 1, 1, 1); idle(1);
        chk(wiper_pos == 7, "R4", longint'(wiper_pos), 7);
        // mixed stimulus against the model
        phase = "R7";
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(lf[7:0] == 8'h5A, int'(lf[13:8]), lf[4:2] == 3'b101, int'(lf[11:6]),
                  lf[5:3] == 3'b011, int'(lf[15:10]), lf[1] | lf[9], lf[0], lf[14]);
        end
        idle(0);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule